// File: doc/BRIEF.md
# Three-Port Memory Stage Stall Control

This block is the sequencing logic for the memory stage of an in-order pipeline that can carry up to three memory operations in one instruction group. Each lane arrives as a held EX/MEM record (valid, read, write, address, store data, ALU result, destination and program counter). All lanes talk to one shared, coherent data cache through a separate request/ready handshake per lane. The block issues each lane's access, remembers which lanes have finished, and raises a single stall that keeps the whole EX/MEM group in place until every lane is complete.

Lane 0 leads. Lanes 1 and 2 do not start their access until lane 0 has nothing to do or has already finished in an earlier cycle, so accesses take effect in slot order. A lane that has finished is never sent to the cache again while the group waits for a slower lane. When the group leaves, the MEM/WB register takes the load data of every reading lane, its ALU result and its write-back select. While the group waits, the MEM/WB valid bits are zero.

The upstream stage must hold the EX/MEM inputs unchanged while stall is high.

Top module: `mem3_stage`

## Requirements
- R1: Lanes share one cache view. A load in lane 1 or 2 to an address that lane 0 stores in the same group returns the stored data.
- R2: Lane 1 and lane 2 raise c_req only when lane 0 has no memory operation or finished its access in an earlier cycle. Lane 0 never requests in a cycle where lane 1 or 2 requests.
- R3: stall is high in a cycle exactly when some valid memory lane has not finished, where finished means it completed a handshake (c_req and c_ready both high) in this cycle or an earlier cycle of the same group.
- R4: In the cycle after any stalled cycle, every wb_valid bit is 0.
- R5: After a lane completes a handshake, it raises no further c_req until the group advances, so each store is written to the cache exactly once.
- R6: On the edge that ends a group with stall low, wb_valid takes ex_valid. For a lane with read set and write clear, wb_m2r is 1 and wb_data holds the cache data of that lane's handshake, on lanes 1 and 2 as well as lane 0. wb_dst and wb_alu take the lane's fields.
- R7: A lane with write set is a store and drives c_we high with its request. A valid lane with neither read nor write set sends no request, passes its ALU result with wb_m2r 0, and an invalid lane sends no request and gives wb_valid 0.
- R8: While a lane requests, c_tag for that lane carries the program counter of the lane's instruction.
- R9: After reset, with no valid input, stall, c_req and wb_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ex_valid | input | NPORT | Lane holds an instruction |
| ex_rd | input | NPORT | Lane is a load |
| ex_wr | input | NPORT | Lane is a store |
| ex_addr | input | NPORT*ADDR_W | Access address, lane i at bits [i*ADDR_W +: ADDR_W] |
| ex_wdata | input | NPORT*DATA_W | Store data per lane |
| ex_alu | input | NPORT*DATA_W | ALU result per lane |
| ex_dst | input | NPORT*DST_W | Destination register per lane |
| ex_pc | input | NPORT*PC_W | Program counter per lane |
| stall | output | 1 | Hold the whole EX/MEM group |
| c_req | output | NPORT | Cache request per lane |
| c_we | output | NPORT | Request is a write |
| c_addr | output | NPORT*ADDR_W | Request address per lane |
| c_wdata | output | NPORT*DATA_W | Request write data per lane |
| c_tag | output | NPORT*PC_W | Program counter of the outstanding request |
| c_ready | input | NPORT | Cache accepts or completes the request this cycle |
| c_rdata | input | NPORT*DATA_W | Load data, valid with c_ready |
| wb_valid | output | NPORT | MEM/WB valid per lane |
| wb_m2r | output | NPORT | Write-back selects load data |
| wb_data | output | NPORT*DATA_W | Load data per lane |
| wb_alu | output | NPORT*DATA_W | ALU result per lane |
| wb_dst | output | NPORT*DST_W | Destination register per lane |

## Verification
The bench sweeps every mix of invalid, plain, load and store lanes against every choice of short or long cache latency per lane, and predicts the stall length from lane 0's latency plus the slowest later lane. A design that let lanes 1 and 2 start beside lane 0 would end groups early and fail that count, and a design that reissued a finished lane while a slower one held the group would write a store twice. A directed group where lane 0 stores and lanes 1 and 2 load the same address shows stale data if ordering or sharing breaks. The bench also checks that later lanes return real load data with the write-back select set, rather than zero, and that the write-back bubble appears in every stalled cycle.

// File: rtl/mem3_pkg.sv
package mem3_pkg;
    localparam int NPORT_DEF  = 3;
    localparam int DATA_W_DEF = 32;
    localparam int ADDR_W_DEF = 16;
    localparam int PC_W_DEF   = 16;
    localparam int DST_W_DEF  = 5;
endpackage

// File: rtl/mem3_port.sv
// One memory lane: issue gating, completion flag, outstanding tag, load capture.
module mem3_port #(
    parameter int DATA_W = mem3_pkg::DATA_W_DEF,
    parameter int PC_W   = mem3_pkg::PC_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              need,
    input  logic              allow,
    input  logic              advance,
    input  logic [PC_W-1:0]   pc,
    input  logic              c_ready,
    input  logic [DATA_W-1:0] c_rdata,
    output logic              req,
    output logic              done,
    output logic              fin,
    output logic [DATA_W-1:0] ldata,
    output logic [PC_W-1:0]   tag
);
    typedef struct packed {
        logic              done;
        logic              pend;
        logic [PC_W-1:0]   pc;
        logic [DATA_W-1:0] data;
    } lane_t;

    lane_t st_d, st_q;
    logic  hs;

    always_comb begin
        req   = need & ~st_q.done & allow;
        hs    = req & c_ready;
        fin   = ~need | st_q.done | hs;
        ldata = hs ? c_rdata : st_q.data;
        tag   = st_q.pend ? st_q.pc : pc;
        done  = st_q.done;

        st_d = st_q;
        if (hs) begin
            st_d.data = c_rdata;
        end
        if (advance) begin
            st_d.done = 1'b0;
            st_d.pend = 1'b0;
        end else begin
            st_d.done = st_q.done | hs;
            st_d.pend = req & ~hs;
            if (req & ~st_q.pend) begin
                st_d.pc = pc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mem3_wb_reg.sv
// MEM/WB register for all lanes: loads on advance, bubbles otherwise.
module mem3_wb_reg #(
    parameter int NPORT  = mem3_pkg::NPORT_DEF,
    parameter int DATA_W = mem3_pkg::DATA_W_DEF,
    parameter int DST_W  = mem3_pkg::DST_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    advance,
    input  logic [NPORT-1:0]        in_valid,
    input  logic [NPORT-1:0]        in_m2r,
    input  logic [NPORT*DATA_W-1:0] in_data,
    input  logic [NPORT*DATA_W-1:0] in_alu,
    input  logic [NPORT*DST_W-1:0]  in_dst,
    output logic [NPORT-1:0]        wb_valid,
    output logic [NPORT-1:0]        wb_m2r,
    output logic [NPORT*DATA_W-1:0] wb_data,
    output logic [NPORT*DATA_W-1:0] wb_alu,
    output logic [NPORT*DST_W-1:0]  wb_dst
);
    typedef struct packed {
        logic [NPORT-1:0]        valid;
        logic [NPORT-1:0]        m2r;
        logic [NPORT*DATA_W-1:0] data;
        logic [NPORT*DATA_W-1:0] alu;
        logic [NPORT*DST_W-1:0]  dst;
    } wb_t;

    wb_t wb_d, wb_q;

    always_comb begin
        wb_d = wb_q;
        if (advance) begin
            wb_d.valid = in_valid;
            wb_d.m2r   = in_m2r;
            wb_d.data  = in_data;
            wb_d.alu   = in_alu;
            wb_d.dst   = in_dst;
        end else begin
            wb_d.valid = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_q <= '0;
        end else begin
            wb_q <= wb_d;
        end
    end

    assign wb_valid = wb_q.valid;
    assign wb_m2r   = wb_q.m2r;
    assign wb_data  = wb_q.data;
    assign wb_alu   = wb_q.alu;
    assign wb_dst   = wb_q.dst;
endmodule

// File: rtl/mem3_stage.sv
// Three-lane memory stage: slot-ordered issue, one global stall, MEM/WB register.
module mem3_stage #(
    parameter int NPORT  = mem3_pkg::NPORT_DEF,
    parameter int DATA_W = mem3_pkg::DATA_W_DEF,
    parameter int ADDR_W = mem3_pkg::ADDR_W_DEF,
    parameter int PC_W   = mem3_pkg::PC_W_DEF,
    parameter int DST_W  = mem3_pkg::DST_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        ex_valid,
    input  logic [NPORT-1:0]        ex_rd,
    input  logic [NPORT-1:0]        ex_wr,
    input  logic [NPORT*ADDR_W-1:0] ex_addr,
    input  logic [NPORT*DATA_W-1:0] ex_wdata,
    input  logic [NPORT*DATA_W-1:0] ex_alu,
    input  logic [NPORT*DST_W-1:0]  ex_dst,
    input  logic [NPORT*PC_W-1:0]   ex_pc,
    output logic                    stall,
    output logic [NPORT-1:0]        c_req,
    output logic [NPORT-1:0]        c_we,
    output logic [NPORT*ADDR_W-1:0] c_addr,
    output logic [NPORT*DATA_W-1:0] c_wdata,
    output logic [NPORT*PC_W-1:0]   c_tag,
    input  logic [NPORT-1:0]        c_ready,
    input  logic [NPORT*DATA_W-1:0] c_rdata,
    output logic [NPORT-1:0]        wb_valid,
    output logic [NPORT-1:0]        wb_m2r,
    output logic [NPORT*DATA_W-1:0] wb_data,
    output logic [NPORT*DATA_W-1:0] wb_alu,
    output logic [NPORT*DST_W-1:0]  wb_dst
);
    logic [NPORT-1:0]        need;
    logic [NPORT-1:0]        allow;
    logic [NPORT-1:0]        lane_done;
    logic [NPORT-1:0]        lane_fin;
    logic [NPORT-1:0]        lane_req;
    logic [NPORT*DATA_W-1:0] lane_data;
    logic                    advance;

    assign need    = ex_valid & (ex_rd | ex_wr);
    assign advance = &lane_fin;
    assign stall   = ~advance;
    assign c_req   = lane_req;
    assign c_we    = lane_req & ex_wr;
    assign c_addr  = ex_addr;
    assign c_wdata = ex_wdata;

    for (genvar i = 0; i < NPORT; i++) begin : g_lane
        if (i == 0) begin : g_lead
            assign allow[i] = 1'b1;
        end else begin : g_follow
            // R2: later lanes wait for the lead lane to be clear
            assign allow[i] = ~need[0] | lane_done[0];
        end

        mem3_port #(
            .DATA_W (DATA_W),
            .PC_W   (PC_W)
        ) i_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .need    (need[i]),
            .allow   (allow[i]),
            .advance (advance),
            .pc      (ex_pc[i*PC_W +: PC_W]),
            .c_ready (c_ready[i]),
            .c_rdata (c_rdata[i*DATA_W +: DATA_W]),
            .req     (lane_req[i]),
            .done    (lane_done[i]),
            .fin     (lane_fin[i]),
            .ldata   (lane_data[i*DATA_W +: DATA_W]),
            .tag     (c_tag[i*PC_W +: PC_W])
        );
    end

    mem3_wb_reg #(
        .NPORT  (NPORT),
        .DATA_W (DATA_W),
        .DST_W  (DST_W)
    ) i_wb (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .in_valid (ex_valid),
        .in_m2r   (ex_valid & ex_rd & ~ex_wr),
        .in_data  (lane_data),
        .in_alu   (ex_alu),
        .in_dst   (ex_dst),
        .wb_valid (wb_valid),
        .wb_m2r   (wb_m2r),
        .wb_data  (wb_data),
        .wb_alu   (wb_alu),
        .wb_dst   (wb_dst)
    );
endmodule

// File: rtl/mem3_stall_chk.sv
module mem3_stall_chk #(
    parameter int NPORT = mem3_pkg::NPORT_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stall,
    input logic [NPORT-1:0] c_req,
    input logic [NPORT-1:0] c_ready,
    input logic [NPORT-1:0] ex_valid,
    input logic [NPORT-1:0] ex_rd,
    input logic [NPORT-1:0] ex_wr,
    input logic [NPORT-1:0] wb_valid
);
    a_r4_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (wb_valid == '0));

    a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (wb_valid == $past(ex_valid)));

    for (genvar i = 0; i < NPORT; i++) begin : g_chk
        a_r3_wait_stalls: assert property (@(posedge clk) disable iff (!rst_n)
            (c_req[i] && !c_ready[i]) |-> stall);

        a_r5_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
            (c_req[i] && c_ready[i] && stall) |=> !c_req[i]);

        a_r7_mem_only: assert property (@(posedge clk) disable iff (!rst_n)
            c_req[i] |-> (ex_valid[i] && (ex_rd[i] || ex_wr[i])));

        if (i > 0) begin : g_order
            a_r2_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
                c_req[i] |-> !c_req[0]);
        end
    end
endmodule

bind mem3_stage mem3_stall_chk #(.NPORT(NPORT)) i_stall_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .c_req    (c_req),
    .c_ready  (c_ready),
    .ex_valid (ex_valid),
    .ex_rd    (ex_rd),
    .ex_wr    (ex_wr),
    .wb_valid (wb_valid)
);

// File: tb/test_mem3_stage.sv
module test_mem3_stage;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NP = 3;
    localparam int DW = 32;
    localparam int AW = 16;
    localparam int PW = 16;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NP-1:0]    ex_valid = '0, ex_rd = '0, ex_wr = '0;
    logic [NP*AW-1:0] ex_addr = '0;
    logic [NP*DW-1:0] ex_wdata = '0, ex_alu = '0;
    logic [NP*RW-1:0] ex_dst = '0;
    logic [NP*PW-1:0] ex_pc = '0;
    logic             stall;
    logic [NP-1:0]    c_req, c_we;
    logic [NP*AW-1:0] c_addr;
    logic [NP*DW-1:0] c_wdata;
    logic [NP*PW-1:0] c_tag;
    logic [NP-1:0]    c_ready = '0;
    logic [NP*DW-1:0] c_rdata = '0;
    logic [NP-1:0]    wb_valid, wb_m2r;
    logic [NP*DW-1:0] wb_data, wb_alu;
    logic [NP*RW-1:0] wb_dst;

    mem3_stage i_mem3_stage (
        .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_rd(ex_rd), .ex_wr(ex_wr),
        .ex_addr(ex_addr), .ex_wdata(ex_wdata), .ex_alu(ex_alu), .ex_dst(ex_dst),
        .ex_pc(ex_pc), .stall(stall), .c_req(c_req), .c_we(c_we), .c_addr(c_addr),
        .c_wdata(c_wdata), .c_tag(c_tag), .c_ready(c_ready), .c_rdata(c_rdata),
        .wb_valid(wb_valid), .wb_m2r(wb_m2r), .wb_data(wb_data), .wb_alu(wb_alu),
        .wb_dst(wb_dst)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // shared cache model and per-lane stimulus (op: 0 invalid, 1 plain, 2 load, 3 store)
    logic [DW-1:0] mem [256];
    int            op  [NP];
    int            lat [NP];
    int            wcnt[NP];
    int            stcnt[NP];
    logic [7:0]    adr [NP];
    logic [DW-1:0] wd  [NP];
    logic [DW-1:0] exp_ld[NP];
    logic [DW-1:0] exp_alu[NP];
    logic [RW-1:0] exp_dst[NP];
    logic [PW-1:0] exp_pc[NP];
    bit            coh = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    initial begin
        wait (cyc > 150000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic int exp_stall();
        int mx = 0;
        bit later = 1'b0;
        for (int i = 1; i < NP; i++) begin
            if (op[i] >= 2) begin
                later = 1'b1;
                if (lat[i] > mx) mx = lat[i];
            end
        end
        if (op[0] >= 2) return lat[0] + (later ? 1 + mx : 0);
        return mx;
    endfunction

    task automatic run_group(input int gid);
        int  scount = 0;
        int  guard = 0;
        bit  nogo = 1'b0;
        bit  st;
        logic [NP-1:0] rdy;
        for (int i = 0; i < NP; i++) begin
            ex_valid[i] = (op[i] != 0);
            ex_rd[i]    = (op[i] == 0) || (op[i] == 2);
            ex_wr[i]    = (op[i] == 3);
            ex_addr[i*AW +: AW]  = {8'h00, adr[i]};
            ex_wdata[i*DW +: DW] = wd[i];
            exp_alu[i] = 32'hA000_0000 | (gid << 4) | i;
            exp_dst[i] = RW'((gid + i) % 32);
            exp_pc[i]  = PW'(gid * 4 + i);
            ex_alu[i*DW +: DW] = exp_alu[i];
            ex_dst[i*RW +: RW] = exp_dst[i];
            ex_pc[i*PW +: PW]  = exp_pc[i];
            exp_ld[i] = (coh && i > 0) ? wd[0] : mem[adr[i]];
            wcnt[i]  = 0;
            stcnt[i] = 0;
        end
        forever begin
            #0.5;
            for (int i = 0; i < NP; i++) begin
                rdy[i] = c_req[i] && (wcnt[i] == lat[i]);
                c_rdata[i*DW +: DW] = mem[c_addr[i*AW +: 8]];
            end
            c_ready = rdy;
            #0.5;
            for (int i = 0; i < NP; i++) begin
                if (op[i] < 2 && c_req[i]) nogo = 1'b1;
                if (rdy[i]) begin
                    chk(c_tag[i*PW +: PW] == exp_pc[i], "R8", "tag",
                        c_tag[i*PW +: PW], exp_pc[i]);
                    if (c_we[i]) begin
                        mem[c_addr[i*AW +: 8]] = c_wdata[i*DW +: DW];
                        stcnt[i]++;
                    end
                    wcnt[i] = 0;
                end else if (c_req[i]) begin
                    wcnt[i]++;
                end
            end
            st = stall;
            if (st) scount++;
            @(negedge clk);
            c_ready = '0;
            if (st) chk(wb_valid == '0, "R4", "bubble", wb_valid, 0);
            guard++;
            if (!st || guard > 40) break;
        end
        chk(scount == exp_stall(), (op[0] >= 2) ? "R2" : "R3", "stall cycles",
            scount, exp_stall());
        chk(!nogo, "R7", "no request from non-memory lane", nogo, 0);
        for (int i = 0; i < NP; i++) begin
            chk(wb_valid[i] == (op[i] != 0), "R6", "wb_valid", wb_valid[i], op[i] != 0);
            chk(stcnt[i] == (op[i] == 3 ? 1 : 0), "R5", "store writes",
                stcnt[i], op[i] == 3);
            if (op[i] != 0) begin
                chk(wb_m2r[i] == (op[i] == 2), "R6", "wb_m2r", wb_m2r[i], op[i] == 2);
                chk(wb_dst[i*RW +: RW] == exp_dst[i], "R6", "wb_dst",
                    wb_dst[i*RW +: RW], exp_dst[i]);
            end
            if (op[i] == 1)
                chk(wb_alu[i*DW +: DW] == exp_alu[i], "R7", "alu pass",
                    wb_alu[i*DW +: DW], exp_alu[i]);
            if (op[i] == 2)
                chk(wb_data[i*DW +: DW] == exp_ld[i], coh ? "R1" : "R6", "load data",
                    wb_data[i*DW +: DW], exp_ld[i]);
        end
    endtask

    initial begin
        int gid = 0;
        for (int k = 0; k < 256; k++) mem[k] = (k * 32'h0101_0101) ^ 32'hA5A5_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stall == 1'b0, "R9", "stall after reset", stall, 0);
        chk(c_req == '0, "R9", "c_req after reset", c_req, 0);
        chk(wb_valid == '0, "R9", "wb_valid after reset", wb_valid, 0);

        for (int p = 0; p < 64; p++) begin
            for (int lc = 0; lc < 8; lc++) begin
                for (int i = 0; i < NP; i++) begin
                    op[i]  = (p >> (2 * i)) & 3;
                    lat[i] = ((lc >> i) & 1) * 2;
                    adr[i] = 8'((gid * 3 + i) % 256);
                    wd[i]  = {gid[15:0], 8'h5A, 8'(i)};
                end
                run_group(gid);
                gid++;
            end
        end

        // R1: lane 0 stores, lanes 1 and 2 load the same address in the same group
        coh = 1'b1;
        op  = '{3, 2, 2};
        lat = '{1, 3, 0};
        for (int i = 0; i < NP; i++) adr[i] = 8'h77;
        wd[0] = 32'hC0FF_EE01;
        wd[1] = 32'h0;
        wd[2] = 32'h0;
        run_group(gid);
        gid++;
        coh = 1'b0;
        chk(mem[8'h77] == 32'hC0FF_EE01, "R1", "shared store visible", mem[8'h77], 32'hC0FF_EE01);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule